// File: doc/BRIEF.md
# Operand-Matching Operation Memory

This block sits on the input side of a functional unit in a processor that passes data directly between units. The decoder writes each operation into the next line of a circular store and receives that line's index, the operation address, at once. Results from other units arrive later as operand writes, each naming an operation address and an input port. They may arrive in any order and to any line that holds an operation.

The line at the head of the store goes to the execution unit as soon as every operand its operation needs is present. Operations therefore leave in the order they were written, even though their operands fill lines in arbitrary order. Because a line is handed out only while it is free, a sender never needs an acknowledgment or a retry. The block reports how many lines are free and whether any line is free, so that the decoder can stall when the store is full.

Each operation carries the number of operands it consumes, N. Only ports 0 to N-1 gate its issue, and the remaining port slots are ignored.

Top module: `opnd_match_mem`

## Requirements
- R1: After a synchronous active-low reset, `free_count` equals DEPTH, `line_free` is 1, `op_wr_addr` is 0 and `iss_valid` is 0.
- R2: An accepted operation write is stored at the line shown on `op_wr_addr`. That address then advances by one, wrapping from DEPTH-1 to 0.
- R3: Operations issue strictly in the order they were accepted. `iss_addr`, `iss_code` and `iss_nargs` show the head line.
- R4: An operand write stores `opnd_wr_data` in slot `opnd_wr_port` of line `opnd_wr_addr`. Writes may come in any order. On issue, port p's data appears on `iss_data[p*DW +: DW]`.
- R5: `iss_valid` is 1 only when the head line holds an operation and ports 0 to N-1 of that line hold operands. N is the operation's operand count, and a count above PORTS means all ports. Ports at or above N are ignored, and N=0 issues at once.
- R6: A later line whose operands are complete does not issue while the head line is incomplete.
- R7: When no line is free, `line_free` is 0 and `free_count` is 0. An operation write in that state is ignored: no line is written and the pointer does not move.
- R8: Issue clears the operand flags of the issuing line. A new operation written to that line waits for fresh operands.
- R9: An operation write and an operand write to the same line in the same cycle are both kept.
- R10: `free_count` falls by one for each accepted operation write and rises by one for each issue. It is unchanged when both happen in one cycle.
- R11: While `iss_valid` is 1 and `iss_ready` is 0, the head operation stays presented, unchanged, and does not leave the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wr_en | input | 1 | Operation write request |
| op_wr_code | input | OPW | Operation code to store |
| op_wr_nargs | input | clog2(PORTS+1) | Number of operands the operation needs |
| op_wr_addr | output | clog2(DEPTH) | Line the next operation write goes to |
| line_free | output | 1 | At least one line is free |
| free_count | output | clog2(DEPTH+1) | Number of free lines |
| opnd_wr_en | input | 1 | Operand write strobe |
| opnd_wr_addr | input | clog2(DEPTH) | Operation address of the operand |
| opnd_wr_port | input | clog2(PORTS) | Port slot of the operand |
| opnd_wr_data | input | DW | Operand value |
| iss_ready | input | 1 | Execution unit accepts the head operation |
| iss_valid | output | 1 | Head operation is complete and presented |
| iss_addr | output | clog2(DEPTH) | Line index of the presented operation |
| iss_code | output | OPW | Operation code of the presented operation |
| iss_nargs | output | clog2(PORTS+1) | Operand count of the presented operation |
| iss_data | output | PORTS*DW | Operand slots, port p at bits p*DW |

## Verification
All outputs are decoded from registers, so every effect of an input is due exactly one clock edge later. An operation or operand written at an edge shows in `iss_valid`, `free_count` and `op_wr_addr` right after that edge. An issue at an edge moves `iss_addr` to the next line after the same edge. The bench drives inputs on the falling edge and compares outputs a moment later, before the next rising edge. It keeps a model that it updates from the inputs it applied at each rising edge, so each comparison lines up with the edge that caused the result.

// File: rtl/opm_pkg.sv
// Package opm_pkg
// Width helpers shared by the operand-matching operation memory.
// Assumes every count passed in is at least 1.
package opm_pkg;

    // Index width for n entries, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width that holds the values 0 to n inclusive.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/opm_ptr_ctrl.sv
// Module opm_ptr_ctrl
// Keeps the circular write and read pointers and the free-line count.
// A push is accepted only while a line is free; a pop is taken as given,
// since the caller only pops a present, complete head line.
module opm_ptr_ctrl
    import opm_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push_req,
    input  logic                      pop,
    output logic                      push_acc,
    output logic [idx_w(DEPTH)-1:0]   wptr,
    output logic [idx_w(DEPTH)-1:0]   rptr,
    output logic [cnt_w(DEPTH)-1:0]   free_cnt,
    output logic                      any_free
);
    localparam int AW = idx_w(DEPTH);
    localparam int CW = cnt_w(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Accept a push only when some line is free.
    always_comb begin
        any_free = (free_cnt != '0);
        push_acc = push_req && any_free;
    end

    // Advance the write pointer on each accepted push, wrapping at the last line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (push_acc)
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
    end

    // Advance the read pointer on each issue, wrapping at the last line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rptr <= '0;
        else if (pop)
            rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end

    // Track free lines: a push takes one, a pop returns one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            free_cnt <= CW'(DEPTH);
        else begin
            case ({push_acc, pop})
                2'b10:   free_cnt <= free_cnt - 1'b1;
                2'b01:   free_cnt <= free_cnt + 1'b1;
                default: free_cnt <= free_cnt;
            endcase
        end
    end

    a_r3_rptr_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> rptr == (($past(rptr) == LAST) ? '0 : $past(rptr) + 1'b1));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !any_free && !pop) |=> ($stable(wptr) && free_cnt == '0));

    a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CW'(DEPTH));

endmodule

// File: rtl/opm_line_store.sv
// Module opm_line_store
// Holds per line the operation code, its operand count and one data word
// per port. Operation writes and operand writes use separate write ports,
// so both may hit the same line in one cycle. Read is a mux on rd_addr.
module opm_line_store
    import opm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    parameter int DW    = 32,
    parameter int OPW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_we,
    input  logic [idx_w(DEPTH)-1:0]    op_waddr,
    input  logic [OPW-1:0]             op_code,
    input  logic [cnt_w(PORTS)-1:0]    op_nargs,
    input  logic                       opnd_we,
    input  logic [idx_w(DEPTH)-1:0]    opnd_addr,
    input  logic [idx_w(PORTS)-1:0]    opnd_port,
    input  logic [DW-1:0]              opnd_data,
    input  logic [idx_w(DEPTH)-1:0]    rd_addr,
    output logic [OPW-1:0]             rd_code,
    output logic [cnt_w(PORTS)-1:0]    rd_nargs,
    output logic [PORTS*DW-1:0]        rd_data
);
    localparam int AW = idx_w(DEPTH);
    localparam int NW = cnt_w(PORTS);

    logic [OPW-1:0]      code_q  [DEPTH];
    logic [NW-1:0]       nargs_q [DEPTH];
    logic [PORTS*DW-1:0] data_q  [DEPTH];

    for (genvar l = 0; l < DEPTH; l++) begin : g_line
        // Capture the operation fields when this line is allocated.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                code_q[l]  <= '0;
                nargs_q[l] <= '0;
            end else if (op_we && op_waddr == AW'(l)) begin
                code_q[l]  <= op_code;
                nargs_q[l] <= op_nargs;
            end
        end

        for (genvar p = 0; p < PORTS; p++) begin : g_slot
            // Capture an operand addressed to this line and port.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_q[l][p*DW +: DW] <= '0;
                else if (opnd_we && opnd_addr == AW'(l) && opnd_port == idx_w(PORTS)'(p))
                    data_q[l][p*DW +: DW] <= opnd_data;
            end
        end
    end

    // Present the line selected by the read pointer.
    always_comb begin
        rd_code  = code_q[rd_addr];
        rd_nargs = nargs_q[rd_addr];
        rd_data  = data_q[rd_addr];
    end

endmodule

// File: rtl/opm_match_track.sv
// Module opm_match_track
// Keeps a line-occupied bit and one operand-present flag per port for
// every line, and decides whether the head line may issue. Issue clears
// a line; an operand write landing in the same cycle sets its bit after
// the clear. Operation writes never touch the operand flags.
module opm_match_track
    import opm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PORTS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_we,
    input  logic [idx_w(DEPTH)-1:0]    op_waddr,
    input  logic                       opnd_we,
    input  logic [idx_w(DEPTH)-1:0]    opnd_addr,
    input  logic [idx_w(PORTS)-1:0]    opnd_port,
    input  logic                       issue,
    input  logic [idx_w(DEPTH)-1:0]    rd_addr,
    input  logic [cnt_w(PORTS)-1:0]    rd_nargs,
    output logic [DEPTH-1:0]           occ,
    output logic                       head_ready
);
    localparam int AW = idx_w(DEPTH);
    localparam int PW = idx_w(PORTS);
    localparam int NW = cnt_w(PORTS);

    logic [PORTS-1:0] flag_q [DEPTH];
    logic [PORTS-1:0] need;
    logic [PORTS-1:0] head_flags;

    for (genvar l = 0; l < DEPTH; l++) begin : g_line
        // Mark the line busy on allocation and free on issue.
        always_ff @(posedge clk) begin
            if (!rst_n)
                occ[l] <= 1'b0;
            else if (op_we && op_waddr == AW'(l))
                occ[l] <= 1'b1;
            else if (issue && rd_addr == AW'(l))
                occ[l] <= 1'b0;
        end

        for (genvar p = 0; p < PORTS; p++) begin : g_flag
            // Set on an operand arrival, clear when the line issues.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[l][p] <= 1'b0;
                else if (opnd_we && opnd_addr == AW'(l) && opnd_port == PW'(p))
                    flag_q[l][p] <= 1'b1;
                else if (issue && rd_addr == AW'(l))
                    flag_q[l][p] <= 1'b0;
            end
        end

        a_r8_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (issue && rd_addr == AW'(l) && !(opnd_we && opnd_addr == AW'(l)))
            |=> flag_q[l] == '0);

        a_r9_same_cycle_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (op_we && opnd_we && op_waddr == AW'(l) && opnd_addr == AW'(l))
            |=> (occ[l] && flag_q[l][$past(opnd_port)]));
    end

    // Ports below the operand count are the ones that gate issue.
    for (genvar p = 0; p < PORTS; p++) begin : g_need
        assign need[p] = (NW'(p) < rd_nargs);
    end

    // Head issues when occupied and every needed port holds an operand.
    always_comb begin
        head_flags = flag_q[rd_addr];
        head_ready = occ[rd_addr] && ((head_flags | ~need) == '1);
    end

    a_r5_issue_only_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> occ[rd_addr]);

endmodule

// File: rtl/opnd_match_mem.sv
// Module opnd_match_mem
// Input-side operation memory of a functional unit. Operations are written
// in order at a circular pointer, operands fill lines by operation address
// and port in any order, and the head line issues once its needed operands
// are present. Assumes operands only target lines holding an operation, or
// the line being allocated in the same cycle.
module opnd_match_mem
    import opm_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PORTS = 2,
    parameter int DW    = 32,
    parameter int OPW   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_wr_en,
    input  logic [OPW-1:0]             op_wr_code,
    input  logic [cnt_w(PORTS)-1:0]    op_wr_nargs,
    output logic [idx_w(DEPTH)-1:0]    op_wr_addr,
    output logic                       line_free,
    output logic [cnt_w(DEPTH)-1:0]    free_count,
    input  logic                       opnd_wr_en,
    input  logic [idx_w(DEPTH)-1:0]    opnd_wr_addr,
    input  logic [idx_w(PORTS)-1:0]    opnd_wr_port,
    input  logic [DW-1:0]              opnd_wr_data,
    input  logic                       iss_ready,
    output logic                       iss_valid,
    output logic [idx_w(DEPTH)-1:0]    iss_addr,
    output logic [OPW-1:0]             iss_code,
    output logic [cnt_w(PORTS)-1:0]    iss_nargs,
    output logic [PORTS*DW-1:0]        iss_data
);
    localparam int AW = idx_w(DEPTH);
    localparam int CW = cnt_w(DEPTH);

    logic             push_acc;
    logic             pop;
    logic             head_ready;
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [DEPTH-1:0] occ;

    // An issue happens when the head is complete and the consumer accepts.
    always_comb begin
        iss_valid = head_ready;
        pop       = head_ready && iss_ready;
        iss_addr  = rptr;
        op_wr_addr = wptr;
    end

    opm_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (op_wr_en),
        .pop      (pop),
        .push_acc (push_acc),
        .wptr     (wptr),
        .rptr     (rptr),
        .free_cnt (free_count),
        .any_free (line_free)
    );

    opm_line_store #(.DEPTH(DEPTH), .PORTS(PORTS), .DW(DW), .OPW(OPW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_we     (push_acc),
        .op_waddr  (wptr),
        .op_code   (op_wr_code),
        .op_nargs  (op_wr_nargs),
        .opnd_we   (opnd_wr_en),
        .opnd_addr (opnd_wr_addr),
        .opnd_port (opnd_wr_port),
        .opnd_data (opnd_wr_data),
        .rd_addr   (rptr),
        .rd_code   (iss_code),
        .rd_nargs  (iss_nargs),
        .rd_data   (iss_data)
    );

    opm_match_track #(.DEPTH(DEPTH), .PORTS(PORTS)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_we      (push_acc),
        .op_waddr   (wptr),
        .opnd_we    (opnd_wr_en),
        .opnd_addr  (opnd_wr_addr),
        .opnd_port  (opnd_wr_port),
        .issue      (pop),
        .rd_addr    (rptr),
        .rd_nargs   (iss_nargs),
        .occ        (occ),
        .head_ready (head_ready)
    );

    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        push_acc |-> !occ[wptr]);

    a_r10_count_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'($countones(occ)) + free_count) == CW'(DEPTH));

    a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) && $stable(iss_code)));

endmodule

// File: tb/opnd_match_mem_bench.sv
module opnd_match_mem_bench;
    localparam int DEPTH = 8;
    localparam int PORTS = 2;
    localparam int DW    = 32;
    localparam int OPW   = 8;
    localparam int AW = 3, PW = 1, NW = 2, CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_wr_en = 1'b0;
    logic [OPW-1:0] op_wr_code = '0;
    logic [NW-1:0] op_wr_nargs = '0;
    logic [AW-1:0] op_wr_addr;
    logic line_free;
    logic [CW-1:0] free_count;
    logic opnd_wr_en = 1'b0;
    logic [AW-1:0] opnd_wr_addr = '0;
    logic [PW-1:0] opnd_wr_port = '0;
    logic [DW-1:0] opnd_wr_data = '0;
    logic iss_ready = 1'b0;
    logic iss_valid;
    logic [AW-1:0] iss_addr;
    logic [OPW-1:0] iss_code;
    logic [NW-1:0] iss_nargs;
    logic [PORTS*DW-1:0] iss_data;

    opnd_match_mem #(.DEPTH(DEPTH), .PORTS(PORTS), .DW(DW), .OPW(OPW)) u_opnd_match_mem (
        .clk(clk), .rst_n(rst_n),
        .op_wr_en(op_wr_en), .op_wr_code(op_wr_code), .op_wr_nargs(op_wr_nargs),
        .op_wr_addr(op_wr_addr), .line_free(line_free), .free_count(free_count),
        .opnd_wr_en(opnd_wr_en), .opnd_wr_addr(opnd_wr_addr), .opnd_wr_port(opnd_wr_port),
        .opnd_wr_data(opnd_wr_data), .iss_ready(iss_ready), .iss_valid(iss_valid),
        .iss_addr(iss_addr), .iss_code(iss_code), .iss_nargs(iss_nargs), .iss_data(iss_data)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model of the line store, built from the requirements.
    bit        m_occ  [DEPTH];
    bit [7:0]  m_code [DEPTH];
    bit [1:0]  m_narg [DEPTH];
    bit        m_flag [DEPTH][PORTS];
    bit [31:0] m_dat  [DEPTH][PORTS];
    int m_wp = 0, m_rp = 0, m_free = DEPTH;

    function automatic void chk(string req, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    // Head complete per R5: occupied and ports below the count present.
    function automatic bit exp_ready();
        bit ok = m_occ[m_rp];
        for (int p = 0; p < PORTS; p++)
            if (p < int'(m_narg[m_rp]) && !m_flag[m_rp][p]) ok = 0;
        return ok;
    endfunction

    function automatic logic [63:0] exp_data_masked();
        logic [63:0] v = '0;
        for (int p = 0; p < PORTS; p++)
            if (p < int'(m_narg[m_rp])) v[p*32 +: 32] = m_dat[m_rp][p];
        return v;
    endfunction

    function automatic logic [63:0] act_data_masked();
        logic [63:0] v = '0;
        for (int p = 0; p < PORTS; p++)
            if (p < int'(m_narg[m_rp])) v[p*32 +: 32] = iss_data[p*32 +: 32];
        return v;
    endfunction

    // One cycle: drive at the falling edge, compare, then update the model at the rising edge.
    task automatic step(input bit ow, input bit [7:0] oc, input bit [1:0] on,
                        input bit dw, input int da, input int dp, input bit [31:0] dd,
                        input bit rdy, input string vtag);
        bit ev, fire, acc;
        op_wr_en = ow; op_wr_code = oc; op_wr_nargs = on;
        opnd_wr_en = dw; opnd_wr_addr = AW'(da); opnd_wr_port = PW'(dp); opnd_wr_data = dd;
        iss_ready = rdy;
        #1;
        ev = exp_ready();
        chk("R10", 64'(free_count), 64'(m_free), "free_count");
        chk("R7", 64'(line_free), 64'(m_free != 0), "line_free");
        chk("R2", 64'(op_wr_addr), 64'(m_wp), "op_wr_addr");
        chk(vtag, 64'(iss_valid), 64'(ev), "iss_valid");
        if (ev) begin
            chk("R3", 64'(iss_addr), 64'(m_rp), "iss_addr");
            chk("R3", 64'(iss_code), 64'(m_code[m_rp]), "iss_code");
            chk("R4", act_data_masked(), exp_data_masked(), "iss_data");
        end
        fire = ev && rdy;
        acc = ow && (m_free != 0);
        @(posedge clk);
        if (fire) begin
            m_occ[m_rp] = 0;
            for (int p = 0; p < PORTS; p++) m_flag[m_rp][p] = 0;
            m_rp = (m_rp + 1) % DEPTH;
        end
        if (dw) begin
            m_flag[da][dp] = 1;
            m_dat[da][dp] = dd;
        end
        if (acc) begin
            m_occ[m_wp] = 1; m_code[m_wp] = oc; m_narg[m_wp] = on;
            m_wp = (m_wp + 1) % DEPTH;
        end
        m_free = m_free - (acc ? 1 : 0) + (fire ? 1 : 0);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit rdy, input string vtag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, rdy, vtag);
    endtask

    initial begin : watchdog
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int base;
        void'($urandom(32'h5eed_0042));
        for (int l = 0; l < DEPTH; l++) begin
            m_occ[l] = 0; m_code[l] = 0; m_narg[l] = 0;
            for (int p = 0; p < PORTS; p++) begin m_flag[l][p] = 0; m_dat[l][p] = 0; end
        end
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        #1;
        chk("R1", 64'(free_count), 64'(DEPTH), "free_count");
        chk("R1", 64'(line_free), 64'd1, "line_free");
        chk("R1", 64'(op_wr_addr), 64'd0, "op_wr_addr");
        chk("R1", 64'(iss_valid), 64'd0, "iss_valid");
        @(negedge clk);

        // R6: later complete line must wait behind an incomplete head.
        step(1, 8'hA1, 2, 0, 0, 0, 0, 1, "R6");
        step(1, 8'hB2, 1, 0, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 1, 1, 0, 32'h1111_0001, 1, "R6");
        idle(2, 1, "R6");
        step(0, 0, 0, 1, 0, 1, 32'h2222_0002, 1, "R6");
        step(0, 0, 0, 1, 0, 0, 32'h3333_0003, 1, "R6");
        idle(3, 1, "R6");

        // R5: zero-operand op issues at once; unneeded port is ignored.
        step(1, 8'hC3, 0, 0, 0, 0, 0, 1, "R5");
        idle(2, 1, "R5");
        base = m_wp;
        step(1, 8'hC4, 1, 1, base, 1, 32'hDEAD_0001, 1, "R5");
        idle(2, 1, "R5");
        step(0, 0, 0, 1, base, 0, 32'h0000_0044, 1, "R5");
        idle(2, 1, "R5");

        // R7: fill every line, then an extra write is ignored.
        base = m_wp;
        for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 2, 0, 0, 0, 0, 1, "R7");
        step(1, 8'hEE, 1, 0, 0, 0, 0, 1, "R7");
        idle(2, 1, "R7");
        // R11: complete head held while not ready.
        step(0, 0, 0, 1, base, 0, 32'h5500_0000, 0, "R11");
        step(0, 0, 0, 1, base, 1, 32'h5500_0001, 0, "R11");
        idle(4, 0, "R11");
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 0, 1, (base + i) % DEPTH, 1, 32'(i * 7), 1, "R3");
            step(0, 0, 0, 1, (base + i) % DEPTH, 0, 32'(i * 9 + 1), 1, "R3");
        end
        idle(3, 1, "R3");

        // R8: a reused line waits for fresh operands.
        step(1, 8'h77, 1, 0, 0, 0, 0, 1, "R8");
        idle(3, 1, "R8");
        step(0, 0, 0, 1, (m_wp + DEPTH - 1) % DEPTH, 0, 32'hABCD_0008, 1, "R8");
        idle(2, 1, "R8");

        // R9: operation and operand to the same line in one cycle.
        step(1, 8'h99, 1, 1, m_wp, 0, 32'h0909_0909, 1, "R9");
        idle(2, 1, "R9");

        // Random traffic, checked every cycle against the model (R2..R5, R10).
        for (int t = 0; t < 3000; t++) begin
            bit rdy, ow, dw, fire;
            bit [1:0] on;
            int da, dp;
            rdy = ($urandom_range(0, 3) != 0);
            fire = exp_ready() && rdy;
            ow = ($urandom_range(0, 2) == 0);
            on = 2'($urandom_range(0, 2));
            dw = 0; da = 0; dp = 0;
            if (ow && m_free != 0 && $urandom_range(0, 5) == 0 && on != 0) begin
                dw = 1; da = m_wp; dp = $urandom_range(0, int'(on) - 1);
            end else begin
                base = $urandom_range(0, DEPTH - 1);
                for (int k = 0; k < DEPTH && !dw; k++) begin
                    int l = (base + k) % DEPTH;
                    if (m_occ[l] && !(fire && l == m_rp))
                        for (int p = 0; p < PORTS; p++)
                            if (!dw && p < int'(m_narg[l]) && !m_flag[l][p]) begin
                                dw = ($urandom_range(0, 1) == 1); da = l; dp = p;
                            end
                end
            end
            step(ow, 8'($urandom), on, dw, da, dp, $urandom, rdy, "R5");
        end
        idle(4, 1, "R4");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule